// File: doc/BRIEF.md
# Multi-Mode PCM Serial Data Port

This block is the digital serial port of a voice codec. Once per frame it takes one 8-bit companded sample from a parallel input and shifts it out on the serial data pin. In the same frame it shifts one 8-bit sample in from the serial receive pin and presents it on a parallel output. All bit clocks and frame syncs arrive as level inputs. The block samples them on a fast system clock and acts on their edges, so the port clock must run several times faster than the fastest bit clock.

Two strap inputs and the receive clock pin select one of four framing disciplines. In the two split modes the transmit and receive directions each have their own bit clock and frame sync, and the sync is either a one-bit-wide pulse or a wide pulse. In the two shared modes both directions use the transmit clock and sync. The receive clock pin then becomes a static level that picks one of the two shared modes, and the receive sync pin becomes a static level that picks the first or second 8-bit bearer slot. A power-down input releases the serial output and stops all transfers.

Top module: `pcm_serial_port`

## Requirements
- R1: During and after reset, with no frame sync seen, `dt_en`, `rx_valid` and `tx_taken` are 0.
- R2: Words are sent most significant bit first, one bit per bit time. `dt_out` changes only on a rising edge of the transmit bit clock. In long-sync mode (`shared_sel`=0, `long_sel`=1) the first bit is driven at the first rising bit clock edge that sees the sync high.
- R3: In short-sync mode (`shared_sel`=0, `long_sel`=0) the sync is a one-bit-wide pulse. The first bit is transferred in the bit time after the one in which the pulse was seen.
- R4: Receive data is sampled on the falling bit clock edge, most significant bit first. After the eighth bit, `rx_valid` is high for exactly one port clock with the assembled byte on `rx_word`.
- R5: `dt_en` is high only during the bit times of the active slot and low for all other bit times.
- R6: With `shared_sel`=1 both directions use `tx_bclk` and `tx_fsync`. A high level on `rx_bclk` selects the IDL-style mode and a low level selects the GCI-style mode.
- R7: In the shared modes, `rx_fsync` low selects the first bearer slot, which starts at the sync edge. `rx_fsync` high selects the second slot, which in IDL-style mode starts 10 bit clocks after the first.
- R8: In GCI-style mode the slot timing counts from the first rising clock edge after the sync rises. Each bit lasts two clock periods, and the second slot starts 8 bit times (16 clocks) after the first.
- R9: `tx_word` is captured when the first bit is driven, with a one-cycle `tx_taken` pulse. Later changes to `tx_word` within the frame do not alter the bits sent.
- R10: While `pwr_dn` is high, `dt_en` is low and neither `tx_taken` nor `rx_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock that samples all serial signals |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down: output released, transfers stopped |
| shared_sel | input | 1 | Strap: 1 selects the shared-clock modes |
| long_sel | input | 1 | Strap in split modes: 1 long sync, 0 short sync |
| tx_bclk | input | 1 | Transmit bit clock (shared data clock in shared modes) |
| tx_fsync | input | 1 | Transmit frame sync (shared sync in shared modes) |
| rx_bclk | input | 1 | Receive bit clock, or mode strap in shared modes |
| rx_fsync | input | 1 | Receive frame sync, or slot select in shared modes |
| tx_word | input | 8 | Parallel sample to transmit |
| tx_taken | output | 1 | One-cycle pulse when `tx_word` is captured |
| dt_out | output | 1 | Serial transmit data |
| dt_en | output | 1 | Drive enable of the serial output (0 = high impedance) |
| dr_in | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
A slot counter that is off by one tick moves `dt_en` a whole bit time early or late. The bench catches this at the first bit of the frame, because it compares the enable and data in every bit time. A bad slot offset or bit-duration choice in the shared modes shows up as a missing or misplaced enable window within 16 bit clocks of the sync. A receive shifter that samples at the wrong edge or phase yields a wrong `rx_word` at the end of that same frame. A lost capture of `tx_word` shows up as wrong later bits once the bench changes the word mid-slot.

// File: rtl/pcm_port_pkg.sv
// Shared types for the PCM serial port.
package pcm_port_pkg;

    // Framing discipline decoded from the straps.
    typedef enum logic [1:0] {
        FRM_SHORT = 2'd0,
        FRM_LONG  = 2'd1,
        FRM_IDL   = 2'd2,
        FRM_GCI   = 2'd3
    } frame_mode_e;

endpackage

// File: rtl/pcm_mode_decode.sv
// Decodes the framing mode from the straps and routes clock and sync for the
// receive side. Assumes straps are static while a frame is in flight.
module pcm_mode_decode
    import pcm_port_pkg::*;
#(
    parameter int WORD_BITS = 8,
    parameter int IDL_GAP   = 10,
    parameter int CNT_W     = 6
) (
    input  logic             shared_sel,
    input  logic             long_sel,
    input  logic             tx_bclk,
    input  logic             tx_fsync,
    input  logic             rx_bclk,
    input  logic             rx_fsync,
    output logic             rx_clk_sel,
    output logic             rx_sync_sel,
    output logic             short_sync,
    output logic             two_tick,
    output logic [CNT_W-1:0] slot_off
);

    frame_mode_e mode;

    // Pick the mode from straps; rx_bclk is a level strap in shared modes.
    always_comb begin
        if (shared_sel) mode = rx_bclk ? FRM_IDL : FRM_GCI;
        else            mode = long_sel ? FRM_LONG : FRM_SHORT;
    end

    // Route receive timing and derive slot geometry.
    always_comb begin
        rx_clk_sel  = shared_sel ? tx_bclk  : rx_bclk;
        rx_sync_sel = shared_sel ? tx_fsync : rx_fsync;
        short_sync  = (mode == FRM_SHORT);
        two_tick    = (mode == FRM_GCI);
        slot_off    = '0;
        if (mode == FRM_IDL && rx_fsync) slot_off = CNT_W'(IDL_GAP);
        if (mode == FRM_GCI && rx_fsync) slot_off = CNT_W'(2 * WORD_BITS);
    end

endmodule

// File: rtl/pcm_slot_timer.sv
// Counts bit-clock rising edges from the frame start and reports whether the
// current bit time lies in the selected slot. Bit clock and sync are assumed
// to be slow levels sampled by clk. USE_FALL selects the event reported.
module pcm_slot_timer #(
    parameter int WORD_BITS = 8,
    parameter int CNT_W     = 6,
    parameter bit USE_FALL  = 1'b0,
    localparam int IDX_W    = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             bclk,
    input  logic             fsync,
    input  logic             short_sync,
    input  logic             two_tick,
    input  logic [CNT_W-1:0] slot_off,
    output logic             evt,
    output logic             in_slot,
    output logic             phase0,
    output logic [IDX_W-1:0] idx
);

    localparam logic [CNT_W-1:0] SAT = '1;

    logic             bclk_q, fs_q;
    logic [CNT_W-1:0] cnt, tick_next, tick_now, rel, span;
    logic             rise, fall, start;

    // Edge and frame-start detection.
    always_comb begin
        rise  = bclk & ~bclk_q;
        fall  = ~bclk & bclk_q;
        start = rise & (short_sync ? (~fsync & fs_q) : (fsync & ~fs_q));
        evt   = USE_FALL ? fall : rise;
    end

    // Tick position of the current bit time and slot membership.
    always_comb begin
        if (start)           tick_next = '0;
        else if (cnt == SAT) tick_next = SAT;
        else                 tick_next = cnt + 1'b1;
        tick_now = rise ? tick_next : cnt;
        rel      = tick_now - slot_off;
        span     = two_tick ? CNT_W'(2 * WORD_BITS) : CNT_W'(WORD_BITS);
        in_slot  = ~pwr_dn && (tick_now != SAT) && (tick_now >= slot_off) && (rel < span);
        phase0   = two_tick ? ~rel[0] : 1'b1;
        idx      = two_tick ? rel[IDX_W:1] : rel[IDX_W-1:0];
    end

    // Clock history, sync history and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
            cnt    <= SAT;
        end else begin
            bclk_q <= bclk;
            if (rise) fs_q <= fsync;
            if (pwr_dn)    cnt <= SAT;
            else if (rise) cnt <= tick_next;
        end
    end

endmodule

// File: rtl/pcm_tx_shift.sv
// Captures the parallel word at the first bit of the slot and drives it MSB
// first, updating only on bit-clock rising events.
module pcm_tx_shift #(
    parameter int WORD_BITS = 8,
    localparam int IDX_W    = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_evt,
    input  logic                 in_slot,
    input  logic                 phase0,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic                 dout,
    output logic                 oe,
    output logic                 taken
);

    logic [WORD_BITS-1:0] hold_q;
    logic [IDX_W-1:0]     sel;

    // Bit position within the held word.
    always_comb sel = IDX_W'(WORD_BITS - 1) - idx;

    // Output bit, enable window and capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            dout   <= 1'b0;
            oe     <= 1'b0;
            taken  <= 1'b0;
        end else begin
            taken <= 1'b0;
            if (rise_evt) begin
                if (in_slot && phase0) begin
                    oe <= 1'b1;
                    if (idx == '0) begin
                        hold_q <= tx_word;
                        dout   <= tx_word[WORD_BITS-1];
                        taken  <= 1'b1;
                    end else begin
                        dout <= hold_q[sel];
                    end
                end else if (!in_slot) begin
                    oe <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_rx_shift.sv
// Shifts serial receive data in on falling bit-clock events, MSB first, and
// publishes the word with a one-cycle strobe after the last bit.
module pcm_rx_shift #(
    parameter int WORD_BITS = 8,
    localparam int IDX_W    = $clog2(WORD_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_evt,
    input  logic                 in_slot,
    input  logic                 phase0,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 din,
    output logic [WORD_BITS-1:0] word,
    output logic                 valid
);

    logic [WORD_BITS-1:0] sh_q;
    logic [WORD_BITS-1:0] sh_next;

    // Shift register contents after taking the current bit.
    always_comb sh_next = {sh_q[WORD_BITS-2:0], din};

    // Shift, publish and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (fall_evt && in_slot && phase0) begin
                sh_q <= sh_next;
                if (idx == IDX_W'(WORD_BITS - 1)) begin
                    word  <= sh_next;
                    valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_serial_port.sv
// Multi-mode PCM serial data port: one word per frame in each direction with
// short, long, IDL-style and GCI-style framing. All serial inputs are sampled
// by clk, which must run several times faster than any bit clock.
module pcm_serial_port #(
    parameter int WORD_BITS = 8,
    parameter int IDL_GAP   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_dn,
    input  logic                 shared_sel,
    input  logic                 long_sel,
    input  logic                 tx_bclk,
    input  logic                 tx_fsync,
    input  logic                 rx_bclk,
    input  logic                 rx_fsync,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic                 tx_taken,
    output logic                 dt_out,
    output logic                 dt_en,
    input  logic                 dr_in,
    output logic [WORD_BITS-1:0] rx_word,
    output logic                 rx_valid
);

    localparam int IDX_W    = $clog2(WORD_BITS);
    localparam int MAX_TICK = (4 * WORD_BITS > IDL_GAP + WORD_BITS) ? 4 * WORD_BITS : IDL_GAP + WORD_BITS;
    localparam int CNT_W    = $clog2(MAX_TICK) + 1;

    logic             rx_clk_sel, rx_sync_sel, short_sync, two_tick;
    logic [CNT_W-1:0] slot_off;
    logic             tx_rise, tx_in_slot, tx_phase0;
    logic [IDX_W-1:0] tx_idx;
    logic             rx_fall, rx_in_slot, rx_phase0;
    logic [IDX_W-1:0] rx_idx;
    logic             oe_q;

    pcm_mode_decode #(.WORD_BITS(WORD_BITS), .IDL_GAP(IDL_GAP), .CNT_W(CNT_W)) u_decode (
        .shared_sel(shared_sel), .long_sel(long_sel),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
        .rx_clk_sel(rx_clk_sel), .rx_sync_sel(rx_sync_sel),
        .short_sync(short_sync), .two_tick(two_tick), .slot_off(slot_off)
    );

    pcm_slot_timer #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W), .USE_FALL(1'b0)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .bclk(tx_bclk), .fsync(tx_fsync),
        .short_sync(short_sync), .two_tick(two_tick), .slot_off(slot_off),
        .evt(tx_rise), .in_slot(tx_in_slot), .phase0(tx_phase0), .idx(tx_idx)
    );

    pcm_slot_timer #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W), .USE_FALL(1'b1)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .bclk(rx_clk_sel), .fsync(rx_sync_sel),
        .short_sync(short_sync), .two_tick(two_tick), .slot_off(slot_off),
        .evt(rx_fall), .in_slot(rx_in_slot), .phase0(rx_phase0), .idx(rx_idx)
    );

    pcm_tx_shift #(.WORD_BITS(WORD_BITS)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise_evt(tx_rise), .in_slot(tx_in_slot),
        .phase0(tx_phase0), .idx(tx_idx), .tx_word(tx_word),
        .dout(dt_out), .oe(oe_q), .taken(tx_taken)
    );

    pcm_rx_shift #(.WORD_BITS(WORD_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .fall_evt(rx_fall), .in_slot(rx_in_slot),
        .phase0(rx_phase0), .idx(rx_idx), .din(dr_in),
        .word(rx_word), .valid(rx_valid)
    );

    // Output release while powered down.
    always_comb dt_en = oe_q & ~pwr_dn;

endmodule

// File: rtl/pcm_serial_port_chk.sv
// Port-level properties of the PCM serial port, bound to every instance.
module pcm_serial_port_chk #(
    parameter int WORD_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwr_dn,
    input logic                 tx_bclk,
    input logic                 rx_clk_sel,
    input logic [WORD_BITS-1:0] tx_word,
    input logic                 tx_taken,
    input logic                 dt_out,
    input logic                 dt_en,
    input logic                 rx_valid
);

    AST_PWRDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |-> !dt_en); // R10

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!$past(rx_clk_sel) && $past(rx_clk_sel, 2))); // R4

    AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_taken |=> !tx_taken); // R9

    AST_TAKEN_DRIVES_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_taken && !pwr_dn) |-> (dt_en && dt_out == $past(tx_word[WORD_BITS-1]))); // R9

    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dt_out) |-> ($past(tx_bclk) && !$past(tx_bclk, 2))); // R2

endmodule

bind pcm_serial_port pcm_serial_port_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tx_bclk(tx_bclk),
    .rx_clk_sel(rx_clk_sel), .tx_word(tx_word), .tx_taken(tx_taken),
    .dt_out(dt_out), .dt_en(dt_en), .rx_valid(rx_valid)
);

// File: tb/pcm_serial_port_bench.sv
// Self-checking bench: directed frames in every mode plus seeded random frames.
module pcm_serial_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       shared_sel = 1'b0;
    logic       long_sel = 1'b1;
    logic       tx_bclk = 1'b0;
    logic       tx_fsync = 1'b0;
    logic       rx_bclk = 1'b0;
    logic       rx_fsync = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       dr_in = 1'b0;
    logic       tx_taken, dt_out, dt_en, rx_valid;
    logic [7:0] rx_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int valid_total = 0;
    int taken_total = 0;
    logic [7:0] last_rx = 8'h00;

    always #2.5 clk = ~clk;

    pcm_serial_port u_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .shared_sel(shared_sel), .long_sel(long_sel),
        .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
        .tx_word(tx_word), .tx_taken(tx_taken),
        .dt_out(dt_out), .dt_en(dt_en), .dr_in(dr_in),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rx_valid) begin
            valid_total <= valid_total + 1;
            last_rx     <= rx_word;
        end
        if (tx_taken) taken_total <= taken_total + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Modes: 0 short, 1 long, 2 IDL-style, 3 GCI-style.
    function automatic int first_tick(input int mode, input bit ch);
        int s;
        s = (mode == 0) ? 1 : 0;
        if (mode == 2 && ch) s += 10;
        if (mode == 3 && ch) s += 16;
        return s;
    endfunction

    function automatic int ticks_per_bit(input int mode);
        return (mode == 3) ? 2 : 1;
    endfunction

    task automatic run_frame(input int mode, input bit ch, input bit pd,
                             input logic [7:0] txw, input logic [7:0] rxw, input string req);
        int v0, t0, s, tpb, r, pos;
        bit act, shared, sync;
        shared     = (mode >= 2);
        shared_sel = shared;
        long_sel   = (mode == 1);
        pwr_dn     = pd;
        tx_word    = txw;
        if (shared) begin
            rx_bclk  = (mode == 2);
            rx_fsync = ch;
        end else begin
            rx_bclk  = 1'b0;
        end
        v0  = valid_total;
        t0  = taken_total;
        s   = first_tick(mode, ch);
        tpb = ticks_per_bit(mode);
        for (int t = 0; t < 36; t++) begin
            sync     = (mode == 1) ? (t < 4) : (t == 0);
            tx_fsync = sync;
            if (!shared) rx_fsync = sync;
            wait_clk(2);
            r   = t - s;
            act = !pd && r >= 0 && r < 8 * tpb;
            pos = act ? 7 - r / tpb : 0;
            tx_bclk = 1'b1;
            if (!shared) rx_bclk = 1'b1;
            dr_in = act ? rxw[pos] : 1'($urandom);
            wait_clk(4);
            if (act && r == 0) tx_word = 8'($urandom);  // R9: late change must not matter
            tx_bclk = 1'b0;
            if (!shared) rx_bclk = 1'b0;
            wait_clk(2);
            check(dt_en == act, {req, " R5 enable window"}, dt_en, act);
            if (act) check(dt_out == txw[pos], {req, " R2 serial bit"}, dt_out, txw[pos]);
        end
        wait_clk(1);
        check(taken_total - t0 == (pd ? 0 : 1), {req, " R9 taken count"}, taken_total - t0, pd ? 0 : 1);
        check(valid_total - v0 == (pd ? 0 : 1), {req, " R4 valid count"}, valid_total - v0, pd ? 0 : 1);
        if (!pd) check(last_rx == rxw, {req, " R4 received word"}, last_rx, rxw);
        pwr_dn = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        wait_clk(4);
        check(dt_en == 1'b0 && rx_valid == 1'b0 && tx_taken == 1'b0, "R1 in reset", {dt_en, rx_valid, tx_taken}, 0);
        rst_n = 1'b1;
        wait_clk(8);
        check(dt_en == 1'b0 && rx_valid == 1'b0 && tx_taken == 1'b0, "R1 after reset", {dt_en, rx_valid, tx_taken}, 0);

        run_frame(1, 1'b0, 1'b0, 8'h80, 8'h01, "R2 long");
        run_frame(1, 1'b0, 1'b0, 8'hA5, 8'h5A, "R2 long");
        run_frame(0, 1'b0, 1'b0, 8'h01, 8'h80, "R3 short");
        run_frame(0, 1'b0, 1'b0, 8'hFF, 8'h00, "R3 short");
        run_frame(2, 1'b0, 1'b0, 8'hC3, 8'h3C, "R6 R7 idl slot1");
        run_frame(2, 1'b1, 1'b0, 8'h96, 8'h69, "R7 idl slot2");
        run_frame(3, 1'b0, 1'b0, 8'h5A, 8'hA5, "R6 R8 gci slot1");
        run_frame(3, 1'b1, 1'b0, 8'h81, 8'h7E, "R8 gci slot2");
        run_frame(1, 1'b0, 1'b1, 8'hFF, 8'hFF, "R10 powerdown long");
        run_frame(3, 1'b1, 1'b1, 8'hFF, 8'hFF, "R10 powerdown gci");
        run_frame(0, 1'b0, 1'b0, 8'h42, 8'h24, "R10 recovery");

        for (int k = 0; k < 40; k++) begin
            run_frame(int'($urandom % 4), 1'($urandom), ($urandom % 8) == 0,
                      8'($urandom), 8'($urandom), "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule